// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block sits in the pixel-clock domain and paces a parallel RGB TFT panel with an 800 by 480 visible area. Each line lasts a fixed 1056 pixel clocks. Each frame lasts a fixed 525 lines. The block drives the horizontal and vertical sync strobes, the data-enable strobe and the panel power-state line, and it reports the column and row of the pixel now on the bus.

Pixels come from an upstream source over a ready/valid port. The block raises ready for exactly the cycles in which it needs a visible pixel. It widens a 565, 666 or 888 pixel onto a 24-line colour bus. If the source has no pixel when one is due, the block sends black and latches an underrun flag.

Firmware sets the sync widths, the front porches, the colour depth and the sync polarity while the generator is stopped. The back porches are not set directly: they take whatever is left of the fixed totals. Writes are dropped while the generator runs, and writes with a value outside the legal range are dropped too.

Top module: `lcd_tcon`

## Requirements
- R1: A line is H_TOTAL states long. The horizontal sync output is asserted for the first hsw states of every line, where hsw is register 0.
- R2: A frame is V_TOTAL lines long. The vertical sync output is asserted for the first vsw whole lines of every frame, where vsw is register 2.
- R3: The sync widths must lie in 1..HSW_MAX and 1..VSW_MAX. The front porches (register 1 horizontal, register 3 vertical) must lie in 1..(H_TOTAL-H_ACTIVE-HSW_MAX-1) and 1..(V_TOTAL-V_ACTIVE-VSW_MAX-1). A write with any other value leaves the register unchanged.
- R4: The back porch is derived from the fixed totals. Visible columns are states H_TOTAL-hfp-H_ACTIVE up to H_TOTAL-hfp-1, and visible lines are V_TOTAL-vfp-V_ACTIVE up to V_TOTAL-vfp-1.
- R5: A register write made while run_i or the internal run state is high is ignored.
- R6: de_o is high only for visible pixels. x_o and y_o give the zero-based column and row of that pixel and are 0 otherwise. All of these outputs are aligned with the colour bus.
- R7: pix_ready_o is high in the cycle before a visible pixel appears on the outputs. The pixel accepted in that cycle is the one shown.
- R8: disp_o is low until run_i is applied and goes high one cycle after the run state. While disp_o is low, de_o is low, rgb_o is 0 and both syncs sit at their idle level. Each start begins at column 0 of line 0.
- R9: Register 4 bits [1:0] select the depth. 0 means 565 taken from pix_data_i[15:0] (red [15:11], green [10:5], blue [4:0]). 1 means 666 taken from [17:0] (red [17:12], green [11:6], blue [5:0]). 2 and 3 mean 888 passed straight through. rgb_o is {red, green, blue}, with 8 bits each.
- R10: A field narrower than 8 bits is placed in the top bits of its lane, and the low bits are filled with copies of the field's most significant bits.
- R11: Syncs are active-low after reset. Register 4 bit 2 set to 1 makes them active-high, and the idle level follows.
- R12: If pix_valid_i is low while pix_ready_o is high, that pixel is sent as black and underrun_o goes high. It stays high until the next start.
- R13: After reset, disp_o, de_o, pix_ready_o, rgb_o and underrun_o are 0 and both syncs are 1. The registers reset to hsw=hfp=vsw=vfp=1 and mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start (1) or stop (0) the generator |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select: 0 hsw, 1 hfp, 2 vsw, 3 vfp, 4 mode |
| cfg_data_i | input | 8 | Register write value |
| pix_valid_i | input | 1 | Source has a pixel |
| pix_data_i | input | 24 | Source pixel, packed per R9 |
| pix_ready_o | output | 1 | Block takes a pixel this cycle |
| disp_o | output | 1 | Panel on (1) or standby (0) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| rgb_o | output | 24 | Colour bus {R,G,B} |
| x_o | output | $clog2(H_ACTIVE) | Visible column |
| y_o | output | $clog2(V_ACTIVE) | Visible row |
| underrun_o | output | 1 | Sticky missing-pixel flag |

## Verification
The bench builds the block with an 8 by 4 visible area inside a 20 by 10 total, with HSW_MAX=4 and VSW_MAX=2. A whole frame is then only 200 cycles. That makes it practical to compare every output against an arithmetic model on every cycle, over two full frames for each of four register sets.

Those register sets include both extremes of every sync width and front porch, every depth code and both polarities. Around them, the bench tries each just-out-of-range value, a write made while running, and a single missing pixel. It then checks that the flag clears on the next start.

// File: rtl/lcd_tcon_pkg.sv
package lcd_tcon_pkg;
  localparam int CFG_W = 8;
  localparam int PIX_W = 24;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    DEPTH_565  = 2'd0,
    DEPTH_666  = 2'd1,
    DEPTH_888  = 2'd2,
    DEPTH_888X = 2'd3
  } depth_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_HSW  = 3'd0,
    SEL_HFP  = 3'd1,
    SEL_VSW  = 3'd2,
    SEL_VFP  = 3'd3,
    SEL_MODE = 3'd4
  } sel_e;

  typedef struct packed {
    logic [CFG_W-1:0] hsw;
    logic [CFG_W-1:0] hfp;
    logic [CFG_W-1:0] vsw;
    logic [CFG_W-1:0] vfp;
    logic             pol_inv;
    depth_e           depth;
  } cfg_t;
endpackage

// File: rtl/lcd_tcon_cfg.sv
module lcd_tcon_cfg
  import lcd_tcon_pkg::*;
#(
  parameter int HSW_MAX = 40,
  parameter int HFP_MAX = 215,
  parameter int VSW_MAX = 20,
  parameter int VFP_MAX = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CFG_W-1:0] data_i,
  output cfg_t             cfg_o
);
  localparam logic [CFG_W-1:0] HSW_HI = CFG_W'(HSW_MAX);
  localparam logic [CFG_W-1:0] HFP_HI = CFG_W'(HFP_MAX);
  localparam logic [CFG_W-1:0] VSW_HI = CFG_W'(VSW_MAX);
  localparam logic [CFG_W-1:0] VFP_HI = CFG_W'(VFP_MAX);
  localparam logic [CFG_W-1:0] ONE    = CFG_W'(1);

  cfg_t cfg_q;
  logic nz;

  assign nz    = data_i >= ONE;
  assign cfg_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.hsw     <= ONE;
      cfg_q.hfp     <= ONE;
      cfg_q.vsw     <= ONE;
      cfg_q.vfp     <= ONE;
      cfg_q.pol_inv <= 1'b0;
      cfg_q.depth   <= DEPTH_888;
    end else if (we_i && !lock_i) begin
      case (sel_i)
        SEL_HSW:  if (nz && data_i <= HSW_HI) cfg_q.hsw <= data_i;
        SEL_HFP:  if (nz && data_i <= HFP_HI) cfg_q.hfp <= data_i;
        SEL_VSW:  if (nz && data_i <= VSW_HI) cfg_q.vsw <= data_i;
        SEL_VFP:  if (nz && data_i <= VFP_HI) cfg_q.vfp <= data_i;
        SEL_MODE: begin
          cfg_q.pol_inv <= data_i[2];
          cfg_q.depth   <= depth_e'(data_i[1:0]);
        end
        default: ;
      endcase
    end
  end

  p_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(cfg_q));
  p_hsw_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.hsw >= ONE && cfg_q.hsw <= HSW_HI);
  p_vsw_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.vsw >= ONE && cfg_q.vsw <= VSW_HI);
  p_fp_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.hfp >= ONE && cfg_q.hfp <= HFP_HI && cfg_q.vfp >= ONE && cfg_q.vfp <= VFP_HI);
endmodule

// File: rtl/lcd_tcon_timing.sv
module lcd_tcon_timing
  import lcd_tcon_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_TOTAL  = 1056,
  parameter int V_ACTIVE = 480,
  parameter int V_TOTAL  = 525,
  localparam int HCW = $clog2(H_TOTAL + 1),
  localparam int VCW = $clog2(V_TOTAL + 1),
  localparam int XW  = $clog2(H_ACTIVE),
  localparam int YW  = $clog2(V_ACTIVE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CFG_W-1:0] hsw_i,
  input  logic [CFG_W-1:0] hfp_i,
  input  logic [CFG_W-1:0] vsw_i,
  input  logic [CFG_W-1:0] vfp_i,
  output logic             h_sync_o,
  output logic             v_sync_o,
  output logic             act_o,
  output logic [XW-1:0]    x_o,
  output logic [YW-1:0]    y_o
);
  localparam logic [HCW-1:0] H_LAST = HCW'(H_TOTAL - 1);
  localparam logic [VCW-1:0] V_LAST = VCW'(V_TOTAL - 1);
  localparam logic [HCW-1:0] H_OFS  = HCW'(H_TOTAL - H_ACTIVE);
  localparam logic [VCW-1:0] V_OFS  = VCW'(V_TOTAL - V_ACTIVE);
  localparam logic [HCW-1:0] H_END  = HCW'(H_TOTAL);
  localparam logic [VCW-1:0] V_END  = VCW'(V_TOTAL);

  logic [HCW-1:0] hcnt_q, hstart, hend;
  logic [VCW-1:0] vcnt_q, vstart, vend;
  logic           h_act, v_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (!run_i) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (hcnt_q == H_LAST) begin
      hcnt_q <= '0;
      vcnt_q <= (vcnt_q == V_LAST) ? '0 : vcnt_q + 1'b1;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  // back porch is whatever the totals leave after sync, active and front porch
  assign hstart   = H_OFS - HCW'(hfp_i);
  assign hend     = H_END - HCW'(hfp_i);
  assign vstart   = V_OFS - VCW'(vfp_i);
  assign vend     = V_END - VCW'(vfp_i);
  assign h_act    = hcnt_q >= hstart && hcnt_q < hend;
  assign v_act    = vcnt_q >= vstart && vcnt_q < vend;
  assign act_o    = h_act && v_act;
  assign h_sync_o = hcnt_q < HCW'(hsw_i);
  assign v_sync_o = vcnt_q < VCW'(vsw_i);
  assign x_o      = XW'(hcnt_q - hstart);
  assign y_o      = YW'(vcnt_q - vstart);

  p_hwrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && hcnt_q == H_LAST |=> hcnt_q == '0);
  p_hbound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= H_LAST && vcnt_q <= V_LAST);
  p_vhold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && hcnt_q != H_LAST |=> $stable(vcnt_q));
  p_sync_not_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_sync_o |-> !h_act);
endmodule

// File: rtl/lcd_tcon_expand.sv
module lcd_tcon_expand
  import lcd_tcon_pkg::*;
(
  input  depth_e           depth_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] rgb_o
);
  logic [7:0] r, g, b;

  always_comb begin
    case (depth_i)
      DEPTH_565: begin
        r = {pix_i[15:11], pix_i[15:13]};
        g = {pix_i[10:5],  pix_i[10:9]};
        b = {pix_i[4:0],   pix_i[4:2]};
      end
      DEPTH_666: begin
        r = {pix_i[17:12], pix_i[17:16]};
        g = {pix_i[11:6],  pix_i[11:10]};
        b = {pix_i[5:0],   pix_i[5:4]};
      end
      default: begin
        r = pix_i[23:16];
        g = pix_i[15:8];
        b = pix_i[7:0];
      end
    endcase
  end

  assign rgb_o = {r, g, b};
endmodule

// File: rtl/lcd_tcon.sv
module lcd_tcon
  import lcd_tcon_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_TOTAL  = 1056,
  parameter int V_ACTIVE = 480,
  parameter int V_TOTAL  = 525,
  parameter int HSW_MAX  = 40,
  parameter int VSW_MAX  = 20,
  localparam int XW = $clog2(H_ACTIVE),
  localparam int YW = $clog2(V_ACTIVE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_sel_i,
  input  logic [7:0]       cfg_data_i,
  input  logic             pix_valid_i,
  input  logic [23:0]      pix_data_i,
  output logic             pix_ready_o,
  output logic             disp_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [23:0]      rgb_o,
  output logic [XW-1:0]    x_o,
  output logic [YW-1:0]    y_o,
  output logic             underrun_o
);
  localparam int HFP_MAX = H_TOTAL - H_ACTIVE - HSW_MAX - 1;
  localparam int VFP_MAX = V_TOTAL - V_ACTIVE - VSW_MAX - 1;

  cfg_t             cfg;
  logic             run_q, start;
  logic             h_sync, v_sync, act;
  logic [XW-1:0]    x_cur;
  logic [YW-1:0]    y_cur;
  logic [PIX_W-1:0] rgb_exp;

  assign start       = run_i && !run_q;
  assign pix_ready_o = run_q && act;

  lcd_tcon_cfg #(
    .HSW_MAX(HSW_MAX), .HFP_MAX(HFP_MAX), .VSW_MAX(VSW_MAX), .VFP_MAX(VFP_MAX)
  ) i_cfg (
    .clk_i, .rst_ni,
    .lock_i (run_i || run_q),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg)
  );

  lcd_tcon_timing #(
    .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL)
  ) i_timing (
    .clk_i, .rst_ni,
    .run_i    (run_q),
    .hsw_i    (cfg.hsw),
    .hfp_i    (cfg.hfp),
    .vsw_i    (cfg.vsw),
    .vfp_i    (cfg.vfp),
    .h_sync_o (h_sync),
    .v_sync_o (v_sync),
    .act_o    (act),
    .x_o      (x_cur),
    .y_o      (y_cur)
  );

  lcd_tcon_expand i_expand (
    .depth_i (cfg.depth),
    .pix_i   (pix_data_i),
    .rgb_o   (rgb_exp)
  );

  // one output register stage keeps every pin aligned to the same pixel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      disp_o     <= 1'b0;
      hsync_o    <= 1'b1;
      vsync_o    <= 1'b1;
      de_o       <= 1'b0;
      rgb_o      <= '0;
      x_o        <= '0;
      y_o        <= '0;
      underrun_o <= 1'b0;
    end else begin
      run_q   <= run_i;
      disp_o  <= run_q;
      hsync_o <= (run_q && h_sync) ? cfg.pol_inv : !cfg.pol_inv;
      vsync_o <= (run_q && v_sync) ? cfg.pol_inv : !cfg.pol_inv;
      de_o    <= pix_ready_o;
      rgb_o   <= (pix_ready_o && pix_valid_i) ? rgb_exp : '0;
      x_o     <= pix_ready_o ? x_cur : '0;
      y_o     <= pix_ready_o ? y_cur : '0;
      if (start)                            underrun_o <= 1'b0;
      else if (pix_ready_o && !pix_valid_i) underrun_o <= 1'b1;
    end
  end

  p_de_disp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> disp_o);
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_o |-> !de_o && rgb_o == '0);
  p_ready_de_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |=> de_o);
  p_black_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o && !pix_valid_i |=> rgb_o == '0 && underrun_o);
  p_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o && !start |=> underrun_o);
endmodule

// File: tb/test_lcd_tcon.sv
`timescale 1ns/1ps
module test_lcd_tcon;
  localparam int HA = 8, HT = 20, VA = 4, VT = 10, HSWM = 4, VSWM = 2;
  localparam int XW = $clog2(HA), YW = $clog2(VA);

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic pix_ready, disp, hsync, vsync, de, underrun;
  logic [23:0] rgb;
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lcd_tcon #(.H_ACTIVE(HA), .H_TOTAL(HT), .V_ACTIVE(VA), .V_TOTAL(VT),
             .HSW_MAX(HSWM), .VSW_MAX(VSWM)) i_lcd_tcon (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_data_i(cfg_data), .pix_valid_i(pix_valid), .pix_data_i(pix_data),
    .pix_ready_o(pix_ready), .disp_o(disp), .hsync_o(hsync), .vsync_o(vsync),
    .de_o(de), .rgb_o(rgb), .x_o(x), .y_o(y), .underrun_o(underrun));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(int c);
    return (c * 40503 + 12345) & 24'hFFFFFF;
  endfunction

  function automatic int rep(int v, int w);
    return ((v << (8 - w)) | (v >> (2 * w - 8))) & 8'hFF;
  endfunction

  function automatic int expand(int depth, int d);
    if (depth == 0)
      return (rep((d >> 11) & 31, 5) << 16) | (rep((d >> 5) & 63, 6) << 8) | rep(d & 31, 5);
    if (depth == 1)
      return (rep((d >> 12) & 63, 6) << 16) | (rep((d >> 6) & 63, 6) << 8) | rep(d & 63, 6);
    return d;
  endfunction

  task automatic wr(int sel, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = 8'(data);
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic run_frames(int hsw, int hfp, int vsw, int vfp, int depth, int pol,
                            int ur, int wr_c);
    int hs0 = HT - hfp - HA, vs0 = VT - vfp - VA;
    @(negedge clk);
    run = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= 2 * HT * VT; c++) begin
      int p, h, v, act, ex;
      @(negedge clk);
      if (c == 0) begin
        chk("R12", "underrun cleared at start", underrun, 0);
        chk("R8", "disp before run state", disp, 0);
      end else begin
        p = c - 1; h = p % HT; v = (p / HT) % VT;
        act = (h >= hs0 && h < hs0 + HA && v >= vs0 && v < vs0 + VA) ? 1 : 0;
        ex = act ? ((p == ur) ? 0 : expand(depth, pat(p))) : 0;
        chk("R1/R11", "hsync", hsync, (h < hsw) ? pol : 1 - pol);
        chk("R2/R11", "vsync", vsync, (v < vsw) ? pol : 1 - pol);
        chk("R4/R6", "de", de, act);
        chk("R6", "x", int'(x), act ? h - hs0 : 0);
        chk("R6", "y", int'(y), act ? v - vs0 : 0);
        chk("R9/R10/R12", "rgb", int'(rgb), ex);
        chk("R8", "disp", disp, 1);
        chk("R12", "underrun", underrun, (ur >= 0 && p >= ur) ? 1 : 0);
      end
      h = c % HT; v = (c / HT) % VT;
      chk("R7", "ready", pix_ready,
          (h >= hs0 && h < hs0 + HA && v >= vs0 && v < vs0 + VA) ? 1 : 0);
      pix_valid = (c != ur);
      pix_data  = 24'(pat(c));
      cfg_we    = (c == wr_c);
      cfg_sel   = 3'd0;
      cfg_data  = 8'd2;
      @(posedge clk);
    end
    @(negedge clk);
    run = 1'b0; pix_valid = 1'b0; cfg_we = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R8", "disp off", disp, 0);
    chk("R8", "de off", de, 0);
    chk("R8", "rgb off", int'(rgb), 0);
    chk("R8/R11", "hsync idle", hsync, 1 - pol);
    chk("R8/R11", "vsync idle", vsync, 1 - pol);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "disp", disp, 0);
    chk("R13", "de", de, 0);
    chk("R13", "ready", pix_ready, 0);
    chk("R13", "rgb", int'(rgb), 0);
    chk("R13", "underrun", underrun, 0);
    chk("R13", "hsync", hsync, 1);
    chk("R13", "vsync", vsync, 1);
    // R13 default registers, 888, active-low
    run_frames(1, 1, 1, 1, 2, 0, -1, -1);
    // widest legal settings, 565, inverted; R3 out-of-range writes ignored
    wr(0, 4); wr(1, 7); wr(2, 2); wr(3, 3); wr(4, 4);
    wr(0, 0); wr(0, 5); wr(1, 0); wr(1, 8); wr(2, 0); wr(2, 3); wr(3, 0); wr(3, 4);
    // R5: hsw write at cycle 30 while running must not take effect; R12 missing pixel at 66
    run_frames(4, 7, 2, 3, 0, 1, 66, 30);
    // R5 check continues: hsw still 4 here, then new set with 666
    run_frames(4, 7, 2, 3, 0, 1, -1, -1);
    wr(0, 2); wr(1, 3); wr(2, 1); wr(3, 2); wr(4, 1);
    run_frames(2, 3, 1, 2, 1, 0, -1, -1);
    // R9 depth code 3 behaves as 888, inverted polarity
    wr(4, 7);
    run_frames(2, 3, 1, 2, 3, 1, -1, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule